// File: doc/BRIEF.md
# Pipelined SPI Register Slave

This block lets an external SPI master read and write a small bank of internal registers. The master shifts a 16-bit word in while the slave shifts one out. An incoming word is either a request, which holds a read/write flag and an address, or the data word that follows a write request. The reply to each word comes out during the next frame, so every read result lags its request by one frame. The master collects the last pending result by sending one more all-zero word. That word is itself a read of the status register.

One configuration bit switches on a parity mode. In that mode every frame carries a seventeenth bit, and that bit gives the word odd parity. A word with wrong parity sets a sticky error flag. A read with bad parity still returns the addressed register. A write whose request or data word has bad parity is cancelled. The SPI pins are synchronized into the system clock domain, which must run several times faster than the serial clock. The serial link is the only data path. It has no handshake and no back-pressure: the master alone paces every bit, and the slave has no way to stall it. A select or status pin needs no valid/ready pair.

Top module: `spi_regbank_slave`

## Requirements
- R1: SPI mode 0, MSB first. `spi_din` is sampled on rising `spi_clk` and `spi_dout` changes after falling `spi_clk`. A frame is 16 rising edges while `spi_sel_n` is low. `spi_dout` is 0 while `spi_sel_n` is high.
- R2: The first reply after `spi_sel_n` falls is the status word.
- R3: A request word has bit 15 = 0 for a read and 1 for a write, and the address in bits 14:11. The reply to a read arrives in the next frame.
- R4: A reply word holds the 15-bit zero-extended register value in bits 15:1. Bit 0 makes the total number of ones in the word odd. Storage registers are 12 bits wide, and higher bits read 0.
- R5: After a write request, the next word's bits 11:0 are stored at that address. The reply during that data word is the old register contents. The reply after the data word is always the status word.
- R6: Address 0 is status, with bit 0 the parity-error flag; it is read-only. Address 1 is config, with bit 0 the parity-mode enable. Addresses 2 to 7 are storage. Addresses 8 to 15 read 0 and ignore writes.
- R7: With parity mode on, a frame is 17 rising edges. The 17th `spi_din` bit must make the 17-bit string hold an odd number of ones. The 17th `spi_dout` bit is 0.
- R8: A read with wrong parity sets the error flag and still returns the addressed contents.
- R9: Wrong parity in a write request or in its data word sets the flag and cancels the write.
- R10: The error flag stays set until a read request of address 0 with good parity. That read returns the flag as it was and then clears it.
- R11: A frame cut short by `spi_sel_n` rising changes no register. Raising `spi_sel_n` also drops any pending write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_clk | input | 1 | Serial clock from master |
| spi_sel_n | input | 1 | Active-low slave select |
| spi_din | input | 1 | Serial data from master |
| spi_dout | output | 1 | Serial data to master |

## Verification
Every reply is due exactly one frame after the word that caused it. The status word is due in the first frame of each select period. The bench queues the model's expected reply before each frame starts and pairs it with the word the master collects in that frame. Each bit is read half a serial period after the falling edge, just before the next rising edge. That leaves room for the synchronizer and load delays of a few system clocks, which settle well before the sample.

// File: rtl/spi_regbank_pkg.sv
package spi_regbank_pkg;
  localparam int WORD_W = 16;
  localparam int VAL_W  = 15;
  localparam int CNT_W  = 5;

  // value in bits 15:1, bit 0 chosen so the whole word has odd weight
  function automatic logic [WORD_W-1:0] pack_reply(input logic [VAL_W-1:0] v);
    return {v, ~(^v)};
  endfunction
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_pin,
  input  logic sel_n_pin,
  input  logic din_pin,
  output logic sck_rise,
  output logic sck_fall,
  output logic sel_start,
  output logic sel,
  output logic din_s
);
  localparam int HW = SYNC_STAGES + 1;

  logic [HW-1:0]          sck_p;
  logic [HW-1:0]          sel_p;
  logic [SYNC_STAGES-1:0] din_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p <= '0;
      sel_p <= '1;
      din_p <= '0;
    end else begin
      sck_p <= (sck_p << 1) | HW'(sclk_pin);
      sel_p <= (sel_p << 1) | HW'(sel_n_pin);
      din_p <= (din_p << 1) | SYNC_STAGES'(din_pin);
    end
  end

  assign sck_rise  =  sck_p[SYNC_STAGES-1] & ~sck_p[SYNC_STAGES];
  assign sck_fall  = ~sck_p[SYNC_STAGES-1] &  sck_p[SYNC_STAGES];
  assign sel       = ~sel_p[SYNC_STAGES-1];
  assign sel_start = ~sel_p[SYNC_STAGES-1] &  sel_p[SYNC_STAGES];
  assign din_s     =  din_p[SYNC_STAGES-1];

  AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sck_rise && sck_fall)); // R1
endmodule

// File: rtl/spi_frame_io.sv
module spi_frame_io
  import spi_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              sel_start,
  input  logic              sel,
  input  logic              din_s,
  input  logic              par_mode,
  input  logic [WORD_W-1:0] reply,
  output logic              done,
  output logic [WORD_W-1:0] rx_word,
  output logic              par_ok,
  output logic              dout
);
  localparam logic [CNT_W-1:0] LAST_PLAIN = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] LAST_PAR   = CNT_W'(WORD_W);

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  last_idx;
  logic [WORD_W-1:0] rx_sr;
  logic [WORD_W-1:0] tx_sr;
  logic              pbit;
  logic              load_pend;

  assign last_idx = par_mode ? LAST_PAR : LAST_PLAIN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      pbit      <= 1'b0;
      done      <= 1'b0;
      load_pend <= 1'b0;
    end else begin
      done      <= 1'b0;
      load_pend <= sel_start | done;
      if (!sel) begin
        cnt <= '0;
      end else if (sck_rise) begin
        if (cnt < LAST_PAR) rx_sr <= {rx_sr[WORD_W-2:0], din_s};
        else                pbit  <= din_s;
        if (cnt == last_idx) begin
          cnt  <= '0;
          done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      // fresh reply word replaces the shifter between frames
      if (load_pend)                          tx_sr <= reply;
      else if (sel && sck_fall && cnt != '0)  tx_sr <= tx_sr << 1;
    end
  end

  assign rx_word = rx_sr;
  assign par_ok  = par_mode ? (^{rx_sr, pbit}) : 1'b1;
  assign dout    = sel & tx_sr[WORD_W-1];

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R1
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST_PAR); // R7
  AST_DESELECT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (cnt == '0)); // R11
endmodule

// File: rtl/spi_reg_file.sv
module spi_reg_file
  import spi_regbank_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int REG_W    = 12,
  parameter int NUM_REGS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_start,
  input  logic              done,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              par_ok,
  output logic [WORD_W-1:0] reply,
  output logic              par_mode
);
  localparam int ADDR_LSB = WORD_W - 1 - ADDR_W;
  localparam int IDX_W    = $clog2(NUM_REGS);
  localparam logic [ADDR_W:0] NREG_L = (ADDR_W+1)'(NUM_REGS);
  localparam logic [ADDR_W-1:0] A_STAT = '0;
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(1);

  logic              perr, perr_nxt;
  logic              cfg_par;
  logic              exp_data;
  logic              cancel;
  logic [ADDR_W-1:0] waddr;
  logic [ADDR_W-1:0] rd_addr;
  logic              is_write;
  logic [VAL_W-1:0]  rd_val;
  logic              wr_fire;
  logic [REG_W-1:0]  wr_data;
  logic [REG_W-1:0]  rd_bus [NUM_REGS];

  assign rd_addr  = rx_word[WORD_W-2:ADDR_LSB];
  assign is_write = rx_word[WORD_W-1];
  assign wr_data  = rx_word[REG_W-1:0];
  assign wr_fire  = done & exp_data & par_ok & ~cancel;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i < 2) begin : g_fixed
      assign rd_bus[i] = '0;
    end else begin : g_store
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(i);
      logic [REG_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           q <= '0;
        else if (wr_fire && waddr == MY_ADDR) q <= wr_data;
      end
      assign rd_bus[i] = q;
    end
  end

  always_comb begin
    rd_val = '0;
    if (rd_addr == A_STAT)                rd_val = VAL_W'(perr);
    else if (rd_addr == A_CFG)            rd_val = VAL_W'(cfg_par);
    else if ({1'b0, rd_addr} < NREG_L)    rd_val = VAL_W'(rd_bus[rd_addr[IDX_W-1:0]]);
  end

  always_comb begin
    perr_nxt = perr;
    if (done) begin
      if (!par_ok)                                            perr_nxt = 1'b1;
      else if (!exp_data && !is_write && rd_addr == A_STAT)  perr_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perr     <= 1'b0;
      cfg_par  <= 1'b0;
      exp_data <= 1'b0;
      cancel   <= 1'b0;
      waddr    <= '0;
      reply    <= '0;
    end else begin
      perr <= perr_nxt;
      if (wr_fire && waddr == A_CFG) cfg_par <= wr_data[0];
      if (sel_start) begin
        exp_data <= 1'b0;
        reply    <= pack_reply(VAL_W'(perr));
      end else if (done) begin
        if (exp_data) begin
          exp_data <= 1'b0;
          reply    <= pack_reply(VAL_W'(perr_nxt));
        end else begin
          reply    <= pack_reply(rd_val);
          exp_data <= is_write;
          if (is_write) begin
            waddr  <= rd_addr;
            cancel <= ~par_ok;
          end
        end
      end
    end
  end

  assign par_mode = cfg_par;

  AST_STATUS_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (done && exp_data && !sel_start) |=> (reply == pack_reply(VAL_W'(perr)))); // R5
  AST_PERR_ON_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !par_ok) |=> perr); // R8
  AST_CANCEL_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (done && exp_data && (!par_ok || cancel)) |=> $stable(cfg_par)); // R9
  AST_SESSION_CLEARS_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
    sel_start |=> !exp_data); // R11
  AST_STATUS_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !exp_data && par_ok && !is_write && rd_addr == A_STAT) |=> !perr); // R10
endmodule

// File: rtl/spi_regbank_slave.sv
module spi_regbank_slave
  import spi_regbank_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int REG_W       = 12,
  parameter int NUM_REGS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_clk,
  input  logic spi_sel_n,
  input  logic spi_din,
  output logic spi_dout
);
  logic              sck_rise, sck_fall, sel_start, sel, din_s;
  logic              done, par_ok, par_mode;
  logic [WORD_W-1:0] rx_word, reply;

  spi_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .sclk_pin(spi_clk), .sel_n_pin(spi_sel_n), .din_pin(spi_din),
    .sck_rise(sck_rise), .sck_fall(sck_fall),
    .sel_start(sel_start), .sel(sel), .din_s(din_s)
  );

  spi_frame_io u_frame (
    .clk(clk), .rst_n(rst_n),
    .sck_rise(sck_rise), .sck_fall(sck_fall),
    .sel_start(sel_start), .sel(sel), .din_s(din_s),
    .par_mode(par_mode), .reply(reply),
    .done(done), .rx_word(rx_word), .par_ok(par_ok), .dout(spi_dout)
  );

  spi_reg_file #(.ADDR_W(ADDR_W), .REG_W(REG_W), .NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .sel_start(sel_start), .done(done),
    .rx_word(rx_word), .par_ok(par_ok),
    .reply(reply), .par_mode(par_mode)
  );

  AST_IDLE_DOUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> !spi_dout); // R1
endmodule

// File: tb/test_spi_regbank_slave.sv
`timescale 1ns/1ps
module test_spi_regbank_slave;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_clk = 1'b0;
  logic spi_sel_n = 1'b1;
  logic spi_din = 1'b0;
  logic spi_dout;

  always #2.5 clk = ~clk;

  spi_regbank_slave i_spi_regbank_slave (
    .clk(clk), .rst_n(rst_n), .spi_clk(spi_clk),
    .spi_sel_n(spi_sel_n), .spi_din(spi_din), .spi_dout(spi_dout)
  );

  typedef struct {logic [15:0] v; string tag;} exp_t;
  exp_t        exp_q[$];
  logic [15:0] rx_q[$];
  int vectors = 0;
  int errs = 0;
  bit finished = 0;

  // requirement-level model
  logic        m_cfg = 0, m_perr = 0, m_exp = 0, m_cancel = 0;
  logic [3:0]  m_waddr = 0;
  logic [11:0] m_mem [8];
  logic [15:0] m_reply = 0;

  function automatic logic [15:0] fmt(input logic [14:0] v);
    return {v, ~(^v)};
  endfunction

  function automatic logic [14:0] m_read(input logic [3:0] a);
    if (a == 0) return 15'(m_perr);
    if (a == 1) return 15'(m_cfg);
    if (a < 8)  return 15'(m_mem[a[2:0]]);
    return '0;
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    vectors++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic m_step(input logic [15:0] w, input bit good);
    if (m_exp) begin
      m_exp = 0;
      if (good && !m_cancel) begin
        if (m_waddr == 1) m_cfg = w[0];
        else if (m_waddr >= 2 && m_waddr < 8) m_mem[m_waddr[2:0]] = w[11:0];
      end
      if (!good) m_perr = 1;
      m_reply = fmt(15'(m_perr));
    end else begin
      m_reply = fmt(m_read(w[14:11]));
      if (!good) m_perr = 1;
      else if (!w[15] && w[14:11] == 0) m_perr = 0;
      if (w[15]) begin
        m_exp = 1;
        m_waddr = w[14:11];
        m_cancel = !good;
      end
    end
  endtask

  task automatic open_sel();
    @(negedge clk) spi_sel_n = 1'b0;
    m_exp = 0;
    m_reply = fmt(15'(m_perr));
    repeat (10) @(negedge clk);
  endtask

  task automatic close_sel();
    repeat (10) @(negedge clk);
    spi_sel_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [16:0] bits, input int nb, output logic [16:0] got);
    got = '0;
    for (int i = nb - 1; i >= 0; i--) begin
      spi_din = bits[i];
      repeat (HALF) @(negedge clk);
      got = {got[15:0], spi_dout};
      spi_clk = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_clk = 1'b0;
    end
  endtask

  // driver: queue the expected reply, shift the word, advance the model
  task automatic xfer(input logic [15:0] w, input bit bad, input string tag);
    logic [16:0] got;
    int nb;
    exp_q.push_back('{m_reply, tag});
    nb = m_cfg ? 17 : 16;
    if (m_cfg) begin
      shift_bits({w, (bad ? (^w) : ~(^w))}, 17, got);
      rx_q.push_back(got[16:1]);
      chk("R7 17th dout bit", 16'(got[0]), 16'h0);
    end else begin
      shift_bits({1'b0, w}, 16, got);
      rx_q.push_back(got[15:0]);
    end
    m_step(w, !(m_cfg && bad));
  endtask

  function automatic logic [15:0] rd(input int a);
    return 16'((a & 15) << 11);
  endfunction
  function automatic logic [15:0] wr(input int a);
    return 16'h8000 | 16'((a & 15) << 11);
  endfunction

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      while (rx_q.size() > 0 && exp_q.size() > 0) begin
        exp_t e;
        logic [15:0] r;
        e = exp_q.pop_front();
        r = rx_q.pop_front();
        chk(e.tag, r, e.v);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [16:0] junk;
    for (int i = 0; i < 8; i++) m_mem[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 idle dout", 16'(spi_dout), 16'h0);

    // R2 status first, R5 writes, R3/R4 pipelined reads
    open_sel();
    xfer(16'h0000, 0, "R2 first reply status");
    xfer(wr(2), 0, "R2 status after flush");
    xfer(16'h05A5, 0, "R5 old contents during data");
    xfer(wr(3), 0, "R5 status after data");
    xfer(16'hF123, 0, "R5 old contents reg3");
    xfer(rd(2), 0, "R5 status after data reg3");
    xfer(rd(3), 0, "R3 read reg2 pipelined");
    xfer(16'h0000, 0, "R4 reg3 upper bits zero");
    xfer(16'h0000, 0, "R3 zero word flush");
    close_sel();

    // R6 read-only status, unimplemented addresses
    open_sel();
    xfer(wr(0), 0, "R2 status first");
    xfer(16'h0FFF, 0, "R6 status contents");
    xfer(wr(9), 0, "R6 status after data");
    xfer(16'h0ABC, 0, "R6 unimpl reads zero");
    xfer(rd(0), 0, "R6 status after unimpl write");
    xfer(rd(9), 0, "R6 status unchanged");
    xfer(wr(4), 0, "R6 unimpl still zero");
    xfer(16'h0001, 0, "R4 odd parity zero value");
    xfer(rd(4), 0, "R5 status");
    xfer(16'h0000, 0, "R4 single one value");
    close_sel();

    // R11 cut-short data frame, then pending write dropped
    open_sel();
    xfer(wr(2), 0, "R2 status first");
    shift_bits({1'b0, 16'h0777}, 8, junk);
    close_sel();
    open_sel();
    xfer(16'h0333, 0, "R11 pending write dropped");
    xfer(rd(2), 0, "R11 status");
    xfer(16'h0000, 0, "R11 reg2 unchanged");
    close_sel();

    // R7 parity mode on
    open_sel();
    xfer(wr(1), 0, "R2 status first");
    xfer(16'h0001, 0, "R6 cfg old value");
    xfer(rd(2), 0, "R7 status first 17-bit frame");
    xfer(rd(1), 0, "R7 read reg2 in parity mode");
    // R8 bad parity on read
    xfer(rd(3), 1, "R7 cfg reads one");
    xfer(rd(5), 0, "R8 contents despite bad parity");
    // R9 bad parity on write request
    xfer(wr(2), 1, "R8 reg5 read");
    xfer(16'h0111, 0, "R9 old contents");
    // R9 bad parity on data word
    xfer(wr(3), 0, "R9 status after cancelled write");
    xfer(16'h0222, 1, "R9 old reg3");
    xfer(rd(2), 0, "R9 status flag set");
    xfer(rd(3), 0, "R9 reg2 not written");
    // R10 sticky flag cleared by status read
    xfer(rd(0), 0, "R9 reg3 not written");
    xfer(rd(0), 0, "R10 flag still set");
    xfer(wr(1), 0, "R10 flag cleared");
    xfer(16'h0000, 0, "R6 cfg one");
    xfer(16'h0000, 0, "R5 status after cfg write");
    xfer(16'h0000, 0, "R7 back to 16-bit status");
    close_sel();

    repeat (20) @(negedge clk);
    chk("R1 idle dout at end", 16'(spi_dout), 16'h0);
    finish_run();
  end
endmodule